// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block settles where a small 32-bit processor fetches next once a control-flow instruction has been decoded. It takes the instruction word, the address of that instruction and the value read from the register named in the instruction's rs field. From these it produces the next fetch address, a flag that says the normal sequential flow was left, and the write-back for the link register. The processor has one branch delay slot, so the link value skips both the jump and the slot that follows it.

Four groups of instructions are handled. The first is branches that test only the sign of one register: less than zero, greater or equal to zero, less or equal to zero, and greater than zero. The second is a region-relative absolute jump. The third is the same jump with a link, and the fourth is a jump to an address held in a register. Every other word, including an unknown sub-code under a branch opcode, continues sequentially. The unit is purely combinational. It sits between decode and the fetch address register, and the surrounding pipeline supplies the register value and handles hazards.

Top module: `cf_next_pc`

## Requirements
- R1: A word whose opcode (bits 31:26) is none of 0x0 with function 0x08, 0x1, 0x2, 0x3, 0x6 or 0x7 gives next PC = PC+4, taken low and link write low.
- R2: Opcode 0x1 with sub-code 0x0 (bits 20:16) is taken exactly when bit 31 of the register value is 1.
- R3: Opcode 0x1 with sub-code 0x1 is taken exactly when bit 31 of the register value is 0, which includes zero.
- R4: Opcode 0x6 with sub-code 0x0 is taken exactly when the register value is negative or all-zero.
- R5: Opcode 0x7 with sub-code 0x0 is taken exactly when the register value is positive and non-zero.
- R6: A taken sign-test branch gives next PC = PC + 4 + (sign-extended 16-bit offset in bits 15:0, shifted left by 2). A branch that is not taken gives PC+4, and taken is low.
- R7: Opcode 0x1 with any sub-code other than 0x0 or 0x1, or opcode 0x6 or 0x7 with a non-zero sub-code, behaves as in R1.
- R8: Opcode 0x2 is always taken, and next PC = {bits 31:28 of PC+4, 26-bit field in bits 25:0, 2'b00}.
- R9: Opcode 0x3 gives the same next PC as R8, raises link write, and gives link value PC+8.
- R10: Opcode 0x0 with function code 0x08 (bits 5:0) is always taken, and next PC equals the register value. Opcode 0x0 with any other function code behaves as in R1.
- R11: Link write is high only for opcode 0x3. The link register index output is always 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being resolved |
| pc_i | input | XLEN | Address of that instruction |
| rs_val_i | input | XLEN | Value of the register named in the rs field |
| next_pc_o | output | XLEN | Address to fetch next |
| taken_o | output | 1 | High when flow leaves PC+4 |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index (always 31) |
| link_val_o | output | XLEN | Return address, PC+8 |

## Verification
The unit holds no state, so a wrong decode class or a wrong condition shows up at the ports in the same evaluation as the input word that triggers it. A misread sub-code or opcode appears as a wrong taken flag together with a next PC that is off by the branch displacement. A sign test that confuses zero with positive is exposed only when the register value is exactly zero, the most negative value or the most positive value, so these values are mixed into the random register stream. A slip in the region bits of the jump target appears only when PC+4 crosses a 256 MiB boundary, so the bench places a PC on that edge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_SIGNBR  = 6'h01;
    localparam logic [5:0] OP_JUMP    = 6'h02;
    localparam logic [5:0] OP_JLINK   = 6'h03;
    localparam logic [5:0] OP_LEZ     = 6'h06;
    localparam logic [5:0] OP_GTZ     = 6'h07;
    localparam logic [5:0] FN_JREG    = 6'h08;
    localparam logic [4:0] SUB_LTZ    = 5'h00;
    localparam logic [4:0] SUB_GEZ    = 5'h01;

    typedef enum logic [2:0] {
        CF_SEQ,
        CF_BRANCH,
        CF_JUMP,
        CF_JLINK,
        CF_JREG
    } cf_kind_e;

    typedef enum logic [1:0] {
        CND_LTZ,
        CND_GEZ,
        CND_LEZ,
        CND_GTZ
    } cond_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [4:0] subop_i,
    input  logic [5:0] funct_i,
    output cf_kind_e   kind_o,
    output cond_e      cond_o
);
    always_comb begin
        kind_o = CF_SEQ;
        cond_o = CND_LTZ;
        unique case (opcode_i)
            OP_SPECIAL: begin
                if (funct_i == FN_JREG) kind_o = CF_JREG;
            end
            OP_SIGNBR: begin
                if (subop_i == SUB_LTZ) begin
                    kind_o = CF_BRANCH;
                    cond_o = CND_LTZ;
                end else if (subop_i == SUB_GEZ) begin
                    kind_o = CF_BRANCH;
                    cond_o = CND_GEZ;
                end
            end
            OP_LEZ: begin
                if (subop_i == 5'h00) begin
                    kind_o = CF_BRANCH;
                    cond_o = CND_LEZ;
                end
            end
            OP_GTZ: begin
                if (subop_i == 5'h00) begin
                    kind_o = CF_BRANCH;
                    cond_o = CND_GTZ;
                end
            end
            OP_JUMP:  kind_o = CF_JUMP;
            OP_JLINK: kind_o = CF_JLINK;
            default:  kind_o = CF_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_sign_test.sv
module npc_sign_test
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] value_i,
    input  cond_e           cond_i,
    output logic            pass_o
);
    logic neg;
    logic zero;

    assign neg  = value_i[XLEN-1];
    assign zero = (value_i == '0);

    always_comb begin
        unique case (cond_i)
            CND_LTZ: pass_o = neg;
            CND_GEZ: pass_o = !neg;
            CND_LEZ: pass_o = neg || zero;
            CND_GTZ: pass_o = !neg && !zero;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN    = 32,
    parameter int OFF_W   = 16,
    parameter int JIDX_W  = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   link_o,
    output logic [XLEN-1:0]   branch_o,
    output logic [XLEN-1:0]   jump_o
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int LOW_W = JIDX_W + 2;

    logic [XLEN-1:0] disp;

    assign seq_o    = pc_i + XLEN'(4);
    assign link_o   = pc_i + XLEN'(8);
    assign disp     = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    assign branch_o = seq_o + disp;
    assign jump_o   = {seq_o[XLEN-1:LOW_W], jidx_i, 2'b00};
endmodule

// File: rtl/cf_next_pc.sv
module cf_next_pc
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int LINK_REG = 31
) (
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rs_val_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [4:0]      link_idx_o,
    output logic [XLEN-1:0] link_val_o
);
    cf_kind_e        kind;
    cond_e           cond;
    logic            cond_pass;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;
    logic            unused_rs_field;

    assign unused_rs_field = ^instr_i[25:21];

    npc_decode u_decode (
        .opcode_i (instr_i[31:26]),
        .subop_i  (instr_i[20:16]),
        .funct_i  (instr_i[5:0]),
        .kind_o   (kind),
        .cond_o   (cond)
    );

    npc_sign_test #(.XLEN(XLEN)) u_sign (
        .value_i (rs_val_i),
        .cond_i  (cond),
        .pass_o  (cond_pass)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(16), .JIDX_W(26)) u_target (
        .pc_i     (pc_i),
        .offset_i (instr_i[15:0]),
        .jidx_i   (instr_i[25:0]),
        .seq_o    (seq_pc),
        .link_o   (link_val_o),
        .branch_o (br_pc),
        .jump_o   (jmp_pc)
    );

    always_comb begin
        next_pc_o = seq_pc;
        taken_o   = 1'b0;
        link_we_o = 1'b0;
        unique case (kind)
            CF_BRANCH: begin
                taken_o   = cond_pass;
                next_pc_o = cond_pass ? br_pc : seq_pc;
            end
            CF_JUMP: begin
                taken_o   = 1'b1;
                next_pc_o = jmp_pc;
            end
            CF_JLINK: begin
                taken_o   = 1'b1;
                link_we_o = 1'b1;
                next_pc_o = jmp_pc;
            end
            CF_JREG: begin
                taken_o   = 1'b1;
                next_pc_o = rs_val_i;
            end
            default: begin
                taken_o   = 1'b0;
                next_pc_o = seq_pc;
            end
        endcase
    end

    assign link_idx_o = 5'(LINK_REG);
endmodule

// File: rtl/cf_next_pc_checker.sv
module cf_next_pc_checker #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic [4:0]      link_idx_o,
    input logic [XLEN-1:0] link_val_o
);
    logic [XLEN-1:0] pc4;
    logic            known;

    assign pc4   = pc_i + XLEN'(4);
    assign known = !$isunknown({instr_i, pc_i, rs_val_i});

    always_comb begin
        if (known) begin
            if (!taken_o)
                assert_seq_when_idle_R1: assert (next_pc_o == pc4);
            if (instr_i[31:26] == 6'h01 && instr_i[20:16] == 5'h00)
                assert_ltz_sign_R2: assert (taken_o == rs_val_i[XLEN-1]);
            if (instr_i[31:26] == 6'h02)
                assert_jump_region_R8: assert (taken_o && next_pc_o[XLEN-1:28] == pc4[XLEN-1:28]
                                              && next_pc_o[1:0] == 2'b00);
            if (link_we_o)
                assert_link_value_R9: assert (link_val_o == pc_i + XLEN'(8));
            if (instr_i[31:26] == 6'h00 && instr_i[5:0] == 6'h08)
                assert_jreg_target_R10: assert (taken_o && next_pc_o == rs_val_i);
            assert_link_only_jal_R11: assert (link_we_o == (instr_i[31:26] == 6'h03));
            assert_link_index_R11: assert (link_idx_o == 5'd31);
        end
    end
endmodule

bind cf_next_pc cf_next_pc_checker #(.XLEN(XLEN)) u_cf_next_pc_checker (
    .instr_i    (instr_i),
    .pc_i       (pc_i),
    .rs_val_i   (rs_val_i),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o)
);

// File: tb/test_cf_next_pc.sv
`timescale 1ns/1ps
module test_cf_next_pc;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] rsv;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cf_next_pc i_cf_next_pc (
        .instr_i    (instr),
        .pc_i       (pc),
        .rs_val_i   (rsv),
        .next_pc_o  (next_pc),
        .taken_o    (taken),
        .link_we_o  (link_we),
        .link_idx_o (link_idx),
        .link_val_o (link_val)
    );

    // Requirement tag that a word exercises.
    function automatic string tag_of(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [4:0] so = w[20:16];
        if (op == 6'h01 && so == 5'h00) return "R2";
        if (op == 6'h01 && so == 5'h01) return "R3";
        if (op == 6'h06 && so == 5'h00) return "R4";
        if (op == 6'h07 && so == 5'h00) return "R5";
        if (op == 6'h01 || op == 6'h06 || op == 6'h07) return "R7";
        if (op == 6'h02) return "R8";
        if (op == 6'h03) return "R9";
        if (op == 6'h00) return "R10";
        return "R1";
    endfunction

    function automatic logic exp_taken(input logic [31:0] w, input logic [31:0] r);
        logic [5:0] op = w[31:26];
        logic [4:0] so = w[20:16];
        logic signed [31:0] s = r;
        if (op == 6'h01 && so == 5'h00) return s < 0;
        if (op == 6'h01 && so == 5'h01) return s >= 0;
        if (op == 6'h06 && so == 5'h00) return s <= 0;
        if (op == 6'h07 && so == 5'h00) return s > 0;
        if (op == 6'h02 || op == 6'h03) return 1'b1;
        if (op == 6'h00 && w[5:0] == 6'h08) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] w, input logic [31:0] p,
                                             input logic [31:0] r);
        logic [5:0] op = w[31:26];
        logic [31:0] p4 = p + 32'd4;
        logic signed [31:0] off = 32'(signed'(w[15:0]));
        if (!exp_taken(w, r)) return p4;
        if (op == 6'h02 || op == 6'h03) return {p4[31:28], w[25:0], 2'b00};
        if (op == 6'h00) return r;
        return p4 + 32'(off * 4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (instr %h pc %h rs %h)",
                     req, what, act, exp, instr, pc, rsv);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] p, input logic [31:0] r);
        string t;
        logic  et;
        logic [31:0] en;
        @(negedge clk);
        instr = w;
        pc    = p;
        rsv   = r;
        #2;
        t  = tag_of(w);
        et = exp_taken(w, r);
        en = exp_next(w, p, r);
        check(taken == et, t, "taken", 32'(taken), 32'(et));
        // R6: branch target or fall-through address
        check(next_pc == en, t, "next_pc", next_pc, en);
        // R11: link write only for opcode 0x3, index fixed at 31
        check(link_we == (w[31:26] == 6'h03), "R11", "link_we", 32'(link_we),
              32'(w[31:26] == 6'h03));
        check(link_idx == 5'd31, "R11", "link_idx", 32'(link_idx), 32'd31);
        if (w[31:26] == 6'h03)
            check(link_val == p + 32'd8, "R9", "link_val", link_val, p + 32'd8);
    endtask

    function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [4:0] so,
                                          input logic [15:0] off);
        return {op, 5'd4, so, off};
    endfunction

    function automatic logic [31:0] pick_rs();
        unique case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7fff_ffff;
            3: return 32'hffff_ffff;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [5:0] pick_op();
        unique case ($urandom % 9)
            0: return 6'h00;
            1, 2: return 6'h01;
            3: return 6'h02;
            4: return 6'h03;
            5: return 6'h06;
            6: return 6'h07;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd4410));
        instr = 32'h2000_0000;   // opcode 0x08: not control flow
        pc    = 32'h0000_1000;
        rsv   = 32'h0;
        @(negedge clk); #2;
        // R1: start-up state with a non-control word
        check(next_pc == 32'h0000_1004 && !taken && !link_we, "R1", "idle",
              next_pc, 32'h0000_1004);

        // R2 / R3 boundaries
        apply(mk_br(6'h01, 5'h00, 16'h0010), 32'h100, 32'h8000_0000);
        apply(mk_br(6'h01, 5'h00, 16'h0010), 32'h100, 32'h0);
        apply(mk_br(6'h01, 5'h01, 16'hfff0), 32'h100, 32'h0);
        apply(mk_br(6'h01, 5'h01, 16'hfff0), 32'h100, 32'hffff_ffff);
        // R4 / R5 zero edge
        apply(mk_br(6'h06, 5'h00, 16'h8000), 32'h0004_0000, 32'h0);
        apply(mk_br(6'h06, 5'h00, 16'h8000), 32'h0004_0000, 32'h1);
        apply(mk_br(6'h07, 5'h00, 16'h7fff), 32'h200, 32'h0);
        apply(mk_br(6'h07, 5'h00, 16'h7fff), 32'h200, 32'h7fff_ffff);
        // R7: odd sub-codes fall through
        apply(mk_br(6'h01, 5'h02, 16'h0040), 32'h300, 32'h8000_0000);
        apply(mk_br(6'h07, 5'h01, 16'h0040), 32'h300, 32'h5);
        apply(mk_br(6'h06, 5'h1f, 16'h0040), 32'h300, 32'h0);
        // R8 / R9: region taken from PC+4 across a 256 MiB edge
        apply({6'h02, 26'h3ff_ffff}, 32'h0fff_fffc, 32'h0);
        apply({6'h03, 26'h000_0001}, 32'h0fff_fffc, 32'h0);
        apply({6'h03, 26'h123_4567}, 32'hafff_0000, 32'h0);
        // R10: register jump and a non-matching function code
        apply({6'h00, 5'd9, 15'h0, 6'h08}, 32'h400, 32'hdead_bee0);
        apply({6'h00, 5'd9, 15'h0, 6'h09}, 32'h400, 32'hdead_bee0);
        // R1: unrelated opcode
        apply({6'h23, 26'h0}, 32'h500, 32'h8000_0000);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[31:26] = pick_op();
            if (w[31:26] != 6'h02 && w[31:26] != 6'h03 && ($urandom % 2) == 0)
                w[20:16] = 5'($urandom % 2);
            if (w[31:26] == 6'h00 && ($urandom % 2) == 0)
                w[5:0] = 6'h08;
            apply(w, {$urandom} & 32'hffff_fffc, pick_rs());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule